// File: doc/BRIEF.md
# Ring-Buffer Command Word Reader

This block drains 32-bit command words from a circular queue held in a shared word-addressed RAM. The first four words of that RAM hold the queue's bounds and pointers: the low bound, the high bound, the producer position and the consumer position. All four are byte offsets. When software pulses `run` while the device is both enabled and configured, the block reads these four words and checks that they describe a sane ring. It then works out how many words the producer has queued and walks through the commands one at a time.

Each command opens with an opcode word. The opcode fixes how many argument words follow it. The block presents every argument on a small streaming output and marks the end of each command with a strobe that carries the opcode. After each word it consumes, the block writes the advanced consumer position back to word 3, so the producer always sees how far the consumer has got.

A command whose words have not all arrived is left untouched: the consumer position goes back to the command's first word. An opcode the block does not recognise raises an error flag and ends the run. A run also ends when the queue is empty, when the device is disabled or unconfigured at a command boundary, or when a fixed number of commands have been taken in one run.

Top module: `cmd_ring_reader`

## Requirements
- R1: After reset `busy`, `err`, `cmd_valid` and `arg_valid` are low. A `run` pulse starts a run only when the block is idle and `enable` and `config_done` are both high. Any other pulse causes no memory access and leaves `busy` low.
- R2: A run first reads word 0 (low bound), word 1 (high bound), word 2 (producer) and word 3 (consumer). The ring is rejected, and no command is read and nothing is written, when any of the four has a nonzero value in bits [1:0], when the low bound is below 16, when the high bound exceeds RING_BYTES, when the low bound, producer or consumer is RING_BYTES or above, or when the high bound is below the low bound plus MIN_SPAN. A high bound exactly equal to RING_BYTES, or exactly equal to the low bound plus MIN_SPAN, is accepted.
- R3: The number of available words is (producer − consumer)/4 when the producer is not behind the consumer. Otherwise it is (producer − consumer + high − low)/4.
- R4: Every word is read from RAM word consumer/4. The consumer position then advances by 4, and it is set to the low bound if the result is at or above the high bound. The new consumer position is written to word 3 in the cycle after each read.
- R5: Opcode 1 and opcode 25 take 4 arguments, opcode 2 takes 5, and opcodes 3 and 13 take 6. The arguments appear in ring order on `arg_data` with `arg_valid`, and `arg_idx` counts 0,1,2,... within the command. `cmd_valid` is high together with the last argument, and `cmd_op` holds the opcode at that time.
- R6: When a command's opcode plus its arguments need more words than are available, no argument is presented. Word 3 is written back with the position of that command's opcode, and the run ends.
- R7: An unrecognised opcode sets `err` and ends the run, leaving word 3 pointing just past the opcode. `err` stays high until the next accepted run clears it.
- R8: One run completes at most MAX_CMDS commands. A further run continues from the stored consumer position.
- R9: A run ends without reading more words when no words are available, or when `enable` or `config_done` is low at a command boundary.
- R10: The memory port never reads and writes in the same cycle, and it writes only to word 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start-of-run pulse |
| enable | input | 1 | Device enabled |
| config_done | input | 1 | Ring memory configured |
| mem_rd | output | 1 | RAM read strobe (data returns next cycle) |
| mem_wr | output | 1 | RAM write strobe |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data |
| busy | output | 1 | Run in progress |
| err | output | 1 | Unknown opcode seen in the last run |
| cmd_valid | output | 1 | Command completed strobe |
| cmd_op | output | 32 | Opcode of the completed command |
| arg_valid | output | 1 | Argument word strobe |
| arg_idx | output | 3 | Argument position within its command |
| arg_data | output | 32 | Argument word |

## Verification
A wrong consumer pointer or a wrong wrap decision shows up at the RAM port within two cycles. It reads the wrong word address, or it writes a wrong value to word 3. Both are visible in the argument stream and in the final word 3. A miscounted available length shows up only at a command boundary, either as a spurious rollback or as a command read past the producer, so the sweeps put the producer exactly one word short of a command and exactly at its end. They do this both with and without a wrap. A wrong argument counter either truncates a command or swallows the next opcode, and the very next `cmd_valid` then carries a wrong opcode.

// File: rtl/cring_pkg.sv
package cring_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTL_REQ,
        S_CTL_CAP,
        S_EVAL,
        S_CMD_BEGIN,
        S_OP_REQ,
        S_OP_CAP,
        S_ARG_REQ,
        S_ARG_CAP,
        S_ROLLBACK
    } rd_state_e;

    localparam logic [31:0] OP_REFRESH   = 32'd1;
    localparam logic [31:0] OP_FILL      = 32'd2;
    localparam logic [31:0] OP_COPY      = 32'd3;
    localparam logic [31:0] OP_ROP_FILL  = 32'd13;
    localparam logic [31:0] OP_REFRESH_V = 32'd25;

    localparam int CTRL_WORDS = 4;
    localparam int STOP_SLOT  = 3;

endpackage

// File: rtl/cring_window.sv
module cring_window #(
    parameter int RING_BYTES = 65536,
    parameter int MIN_SPAN   = 10240
) (
    input  logic [31:0] lo,
    input  logic [31:0] hi,
    input  logic [31:0] head,
    input  logic [31:0] tail,
    output logic [31:0] avail_words
);
    localparam logic [32:0] RING = 33'(RING_BYTES);
    localparam logic [32:0] SPAN = 33'(MIN_SPAN);

    logic        bad;
    logic [31:0] diff;

    always_comb begin
        bad = ((lo | hi | head | tail) & 32'd3) != 32'd0;
        if (lo < 32'd16) bad = 1'b1;
        if ({1'b0, hi} > RING) bad = 1'b1;
        if ({1'b0, lo} >= RING || {1'b0, tail} >= RING || {1'b0, head} >= RING) bad = 1'b1;
        if ({1'b0, hi} < {1'b0, lo} + SPAN) bad = 1'b1;
        diff = head - tail;
        if (head < tail) diff = diff + (hi - lo);
        avail_words = bad ? 32'd0 : (diff >> 2);
    end
endmodule

// File: rtl/cring_decode.sv
module cring_decode
    import cring_pkg::*;
(
    input  logic [31:0] op,
    output logic        known,
    output logic [2:0]  nargs
);
    always_comb begin
        known = 1'b1;
        nargs = 3'd0;
        case (op)
            OP_REFRESH, OP_REFRESH_V: nargs = 3'd4;
            OP_FILL:                  nargs = 3'd5;
            OP_COPY, OP_ROP_FILL:     nargs = 3'd6;
            default:                  known = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmd_ring_reader.sv
module cmd_ring_reader
    import cring_pkg::*;
#(
    parameter int RING_BYTES = 65536,
    parameter int MIN_SPAN   = 10240,
    parameter int MAX_CMDS   = 1023,
    localparam int AW = $clog2(RING_BYTES / 4),
    localparam int CW = $clog2(MAX_CMDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          enable,
    input  logic          config_done,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          busy,
    output logic          err,
    output logic          cmd_valid,
    output logic [31:0]   cmd_op,
    output logic          arg_valid,
    output logic [2:0]    arg_idx,
    output logic [31:0]   arg_data
);
    localparam logic [CW-1:0] CMD_LIMIT = CW'(MAX_CMDS);

    typedef struct packed {
        rd_state_e    st;
        logic [1:0]   ctl_idx;
        logic [31:0]  cmin;
        logic [31:0]  cmax;
        logic [31:0]  cnext;
        logic [31:0]  cstop;
        logic [31:0]  start;
        logic [31:0]  avail;
        logic [2:0]   left;
        logic [2:0]   aidx;
        logic [CW-1:0] ncmd;
        logic         err;
        logic [31:0]  op;
        logic         cmd_valid;
        logic         arg_valid;
        logic [2:0]   arg_idx;
        logic [31:0]  arg_data;
    } rd_regs_t;

    rd_regs_t r_d, r_q;

    logic [31:0] win_avail;
    logic        op_known;
    logic [2:0]  op_nargs;
    logic [31:0] stop_inc;
    logic [31:0] stop_adv;
    logic [31:0] need;

    cring_window #(.RING_BYTES(RING_BYTES), .MIN_SPAN(MIN_SPAN)) u_window (
        .lo(r_q.cmin), .hi(r_q.cmax), .head(r_q.cnext), .tail(r_q.cstop),
        .avail_words(win_avail)
    );

    cring_decode u_decode (.op(mem_rdata), .known(op_known), .nargs(op_nargs));

    assign stop_inc = r_q.cstop + 32'd4;
    assign stop_adv = (stop_inc >= r_q.cmax) ? r_q.cmin : stop_inc;
    assign need     = {29'd0, op_nargs} + 32'd1;

    always_comb begin
        mem_rd    = (r_q.st == S_CTL_REQ) || (r_q.st == S_OP_REQ) || (r_q.st == S_ARG_REQ);
        mem_wr    = (r_q.st == S_OP_CAP) || (r_q.st == S_ARG_CAP) || (r_q.st == S_ROLLBACK);
        mem_wdata = (r_q.st == S_ROLLBACK) ? r_q.cstop : stop_adv;
        if (mem_wr)                 mem_addr = AW'(STOP_SLOT);
        else if (r_q.st == S_CTL_REQ) mem_addr = AW'(r_q.ctl_idx);
        else                        mem_addr = r_q.cstop[AW+1:2];
    end

    always_comb begin
        r_d = r_q;
        r_d.cmd_valid = 1'b0;
        r_d.arg_valid = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (run && enable && config_done) begin
                    r_d.st      = S_CTL_REQ;
                    r_d.ctl_idx = 2'd0;
                    r_d.err     = 1'b0;
                    r_d.ncmd    = '0;
                end
            end
            S_CTL_REQ: r_d.st = S_CTL_CAP;
            S_CTL_CAP: begin
                case (r_q.ctl_idx)
                    2'd0:    r_d.cmin  = mem_rdata;
                    2'd1:    r_d.cmax  = mem_rdata;
                    2'd2:    r_d.cnext = mem_rdata;
                    default: r_d.cstop = mem_rdata;
                endcase
                if (r_q.ctl_idx == 2'(CTRL_WORDS - 1)) begin
                    r_d.st = S_EVAL;
                end else begin
                    r_d.ctl_idx = r_q.ctl_idx + 2'd1;
                    r_d.st      = S_CTL_REQ;
                end
            end
            S_EVAL: begin
                r_d.avail = win_avail;
                r_d.st    = S_CMD_BEGIN;
            end
            S_CMD_BEGIN: begin
                if (!(enable && config_done) || r_q.avail == 32'd0 || r_q.ncmd == CMD_LIMIT) begin
                    r_d.st = S_IDLE;
                end else begin
                    r_d.start = r_q.cstop;
                    r_d.st    = S_OP_REQ;
                end
            end
            S_OP_REQ: r_d.st = S_OP_CAP;
            S_OP_CAP: begin
                r_d.cstop = stop_adv;
                r_d.op    = mem_rdata;
                if (!op_known) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_IDLE;
                end else if (need > r_q.avail) begin
                    r_d.cstop = r_q.start;
                    r_d.st    = S_ROLLBACK;
                end else begin
                    r_d.avail = r_q.avail - need;
                    r_d.left  = op_nargs;
                    r_d.aidx  = 3'd0;
                    r_d.st    = S_ARG_REQ;
                end
            end
            S_ARG_REQ: r_d.st = S_ARG_CAP;
            S_ARG_CAP: begin
                r_d.cstop     = stop_adv;
                r_d.arg_valid = 1'b1;
                r_d.arg_data  = mem_rdata;
                r_d.arg_idx   = r_q.aidx;
                r_d.aidx      = r_q.aidx + 3'd1;
                r_d.left      = r_q.left - 3'd1;
                if (r_q.left == 3'd1) begin
                    r_d.cmd_valid = 1'b1;
                    r_d.ncmd      = r_q.ncmd + 1'b1;
                    r_d.st        = S_CMD_BEGIN;
                end else begin
                    r_d.st = S_ARG_REQ;
                end
            end
            S_ROLLBACK: r_d.st = S_IDLE;
            default:    r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != S_IDLE);
    assign err       = r_q.err;
    assign cmd_valid = r_q.cmd_valid;
    assign cmd_op    = r_q.op;
    assign arg_valid = r_q.arg_valid;
    assign arg_idx   = r_q.arg_idx;
    assign arg_data  = r_q.arg_data;
endmodule

// File: rtl/cmd_ring_reader_chk.sv
module cmd_ring_reader_chk #(
    parameter int AW         = 14,
    parameter int RING_BYTES = 65536
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          busy,
    input logic          err,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          cmd_valid,
    input logic          arg_valid
);
    // R10: single-port RAM is never asked to read and write at once
    p_port_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R4, R10: write-back goes to word 3 with an aligned in-range position
    p_wr_stop_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == AW'(3) && mem_wdata[1:0] == 2'b00
                    && {1'b0, mem_wdata} < 33'(RING_BYTES)));

    // R1: no memory traffic while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    // R1: a run only begins after a run pulse
    p_start_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(run));

    // R2: the first access of a run reads the low-bound word
    p_ctl_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_rd && mem_addr == '0));

    // R5: the command strobe coincides with its last argument
    p_cmd_last_arg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> arg_valid);

    // R7: raising the error flag ends the run
    p_err_ends_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);
endmodule

bind cmd_ring_reader cmd_ring_reader_chk #(.AW(AW), .RING_BYTES(RING_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .busy(busy), .err(err),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cmd_valid(cmd_valid), .arg_valid(arg_valid)
);

// File: tb/cmd_ring_reader_test.sv
module cmd_ring_reader_test;
    localparam int RB = 1024;
    localparam int SP = 256;
    localparam int MC = 4;
    localparam int AW = $clog2(RB / 4);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, run, enable, config_done;
    logic mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic busy, err, cmd_valid, arg_valid;
    logic [31:0] cmd_op, arg_data;
    logic [2:0] arg_idx;

    cmd_ring_reader #(.RING_BYTES(RB), .MIN_SPAN(SP), .MAX_CMDS(MC)) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .enable(enable), .config_done(config_done),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .err(err), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .arg_valid(arg_valid), .arg_idx(arg_idx), .arg_data(arg_data)
    );

    logic [31:0] ram [0:RB/4-1];
    int n_rd = 0, n_wr = 0, n_port_bad = 0;
    always @(posedge clk) begin
        if (mem_rd) begin mem_rdata <= ram[mem_addr]; n_rd <= n_rd + 1; end
        if (mem_wr) begin ram[mem_addr] <= mem_wdata; n_wr <= n_wr + 1; end
        if ((mem_rd && mem_wr) || (mem_wr && mem_addr != AW'(3))) n_port_bad <= n_port_bad + 1;
    end

    logic [31:0] got_arg [0:1023];
    logic [2:0]  got_idx [0:1023];
    logic [31:0] got_op  [0:255];
    int n_arg = 0, n_cmd = 0;
    always @(negedge clk) begin
        if (rst_n && arg_valid) begin got_arg[n_arg] = arg_data; got_idx[n_arg] = arg_idx; n_arg = n_arg + 1; end
        if (rst_n && cmd_valid) begin got_op[n_cmd] = cmd_op; n_cmd = n_cmd + 1; end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int b_arg, b_cmd, b_wr, b_rd;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] adv(input logic [31:0] p, input logic [31:0] mn, input logic [31:0] mx);
        return (p + 4 >= mx) ? mn : p + 4;
    endfunction

    function automatic logic [31:0] pat(input logic [31:0] op, input int k);
        return 32'hC0DE_0000 | (op << 8) | 32'(k);
    endfunction

    task automatic set_ring(input logic [31:0] mn, mx, nx, st);
        ram[0] = mn; ram[1] = mx; ram[2] = nx; ram[3] = st;
    endtask

    task automatic mark();
        b_arg = n_arg; b_cmd = n_cmd; b_wr = n_wr; b_rd = n_rd;
    endtask

    task automatic do_run();
        mark();
        @(negedge clk) run = 1'b1;
        @(negedge clk) run = 1'b0;
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // writes one command with arguments at st, returns the position after it
    task automatic put_cmd(input logic [31:0] op, input int n, input logic [31:0] mn, mx,
                           inout logic [31:0] p);
        ram[p >> 2] = op;
        for (int k = 1; k <= n; k++) begin
            p = adv(p, mn, mx);
            ram[p >> 2] = pat(op, k);
        end
        p = adv(p, mn, mx);
    endtask

    task automatic run_single(input logic [31:0] op, input int n, input logic [31:0] mn, mx, st, input string tag);
        logic [31:0] p;
        p = st;
        put_cmd(op, n, mn, mx, p);
        set_ring(mn, mx, p, st);
        do_run();
        chk(n_cmd - b_cmd == 1, {tag, " one command"}, n_cmd - b_cmd, 1);
        chk(n_arg - b_arg == n, {tag, " R5 arg count"}, n_arg - b_arg, n);
        chk(got_op[b_cmd] == op, {tag, " R5 opcode"}, got_op[b_cmd], op);
        for (int k = 1; k <= n; k++) begin
            chk(got_arg[b_arg + k - 1] == pat(op, k), {tag, " R5 arg data"}, got_arg[b_arg + k - 1], pat(op, k));
            chk(got_idx[b_arg + k - 1] == 3'(k - 1), {tag, " R5 arg index"}, 32'(got_idx[b_arg + k - 1]), k - 1);
        end
        chk(ram[3] == p, {tag, " R4 final consumer"}, ram[3], p);
        chk(err == 1'b0, {tag, " R7 no error"}, 32'(err), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] ops [5];
        int nas [5];
        logic [31:0] p, st, nx;
        ops = '{32'd1, 32'd25, 32'd2, 32'd3, 32'd13};
        nas = '{4, 4, 5, 6, 6};
        for (int i = 0; i < RB / 4; i++) ram[i] = 32'h0;
        rst_n = 0; run = 0; enable = 1; config_done = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !err && !cmd_valid && !arg_valid, "R1 reset state",
            {28'd0, busy, err, cmd_valid, arg_valid}, 0);

        // R1: run ignored unless both enable and config_done
        p = 16; put_cmd(32'd1, 4, 16, 1024, p); set_ring(16, 1024, p, 16);
        enable = 0; do_run();
        chk(n_rd == b_rd && n_cmd == b_cmd, "R1 disabled run ignored", n_rd - b_rd, 0);
        enable = 1; config_done = 0; do_run();
        chk(n_rd == b_rd && n_cmd == b_cmd, "R1 unconfigured run ignored", n_rd - b_rd, 0);
        config_done = 1;

        // R5: every opcode, at differing positions; high bound equal to RING_BYTES
        for (int i = 0; i < 5; i++) run_single(ops[i], nas[i], 16, 1024, 32'(100 + 40 * i), "R5 opcode sweep");

        // R4: wrap at every position of a 7-word command; high bound equal to low+span
        for (int k = 1; k <= 7; k++) run_single(32'd3, 6, 16, 272, 32'(272 - 4 * k), "R4 wrap sweep");

        // R2: each rejection rule
        for (int f = 0; f < 9; f++) begin
            logic [31:0] mn, mx, nxf, stf;
            p = 16; put_cmd(32'd1, 4, 16, 1024, p);
            mn = 16; mx = 1024; nxf = p; stf = 16;
            case (f)
                0: mn = 18;
                1: mx = 1022;
                2: nxf = 38;
                3: stf = 17;
                4: mn = 12;
                5: mx = 1028;
                6: nxf = 1024;
                7: stf = 1024;
                default: mx = 268;
            endcase
            set_ring(mn, mx, nxf, stf);
            do_run();
            chk(n_cmd == b_cmd && n_arg == b_arg, "R2 bad ring no command", n_cmd - b_cmd, 0);
            chk(n_wr == b_wr && ram[3] == stf, "R2 bad ring no write-back", ram[3], stf);
        end

        // R6 and R3: producer one word short or exactly complete, linear
        for (int a = 1; a <= 6; a++) begin
            p = 16; put_cmd(32'd2, 5, 16, 1024, p);
            set_ring(16, 1024, 32'(16 + 4 * a), 16);
            do_run();
            if (a < 6) begin
                chk(n_cmd == b_cmd && n_arg == b_arg, "R6 incomplete no args", n_arg - b_arg, 0);
                chk(ram[3] == 16 && n_wr - b_wr == 2, "R6 consumer restored", ram[3], 16);
            end else begin
                chk(n_cmd - b_cmd == 1 && ram[3] == 40, "R3 exact length accepted", ram[3], 40);
            end
        end

        // R3: available length across the wrap point
        for (int a = 5; a <= 6; a++) begin
            st = 264; p = st; put_cmd(32'd2, 5, 16, 272, p);
            nx = 32'(264 + 4 * a - 256);
            set_ring(16, 272, nx, st);
            do_run();
            if (a == 5)
                chk(n_cmd == b_cmd && ram[3] == 264, "R3 wrapped length short", ram[3], 264);
            else
                chk(n_cmd - b_cmd == 1 && ram[3] == nx, "R3 wrapped length exact", ram[3], nx);
        end

        // R7: unknown opcode
        ram[4] = 32'd7; set_ring(16, 1024, 40, 16);
        do_run();
        chk(err == 1'b1, "R7 error raised", 32'(err), 1);
        chk(n_cmd == b_cmd && n_arg == b_arg, "R7 nothing presented", n_arg - b_arg, 0);
        chk(ram[3] == 20, "R7 consumer past opcode", ram[3], 20);
        run_single(32'd1, 4, 16, 1024, 16, "R7 error cleared");

        // R8: command limit per run
        p = 16;
        for (int i = 0; i < 6; i++) put_cmd(32'd1, 4, 16, 1024, p);
        set_ring(16, 1024, p, 16);
        do_run();
        chk(n_cmd - b_cmd == MC, "R8 limited run count", n_cmd - b_cmd, MC);
        chk(ram[3] == 96, "R8 limited run consumer", ram[3], 96);
        do_run();
        chk(n_cmd - b_cmd == 2 && ram[3] == p, "R8 resumed run", ram[3], p);

        // R9: empty ring
        set_ring(16, 1024, 200, 200);
        do_run();
        chk(n_cmd == b_cmd && n_wr == b_wr && n_rd - b_rd == 4, "R9 empty ring", n_rd - b_rd, 4);

        // R9: enable dropped at a command boundary
        p = 16;
        for (int i = 0; i < 3; i++) put_cmd(32'd1, 4, 16, 1024, p);
        set_ring(16, 1024, p, 16);
        mark();
        @(negedge clk) run = 1'b1;
        @(negedge clk) run = 1'b0;
        for (int i = 0; i < 500 && !cmd_valid; i++) @(negedge clk);
        enable = 0;
        for (int i = 0; i < 500 && busy; i++) @(negedge clk);
        @(negedge clk);
        enable = 1;
        chk(n_cmd - b_cmd == 1 && ram[3] == 36, "R9 stop on disable", ram[3], 36);

        chk(n_port_bad == 0, "R10 port discipline", n_port_bad, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule